// File: doc/BRIEF.md
# Seven-Segment Status Sequencer

This block drives a single seven-segment digit through an external serial shift register, using only a shift clock and a data wire. From a set of mode inputs it picks the symbol that reports the unit's state. In data-receive mode it runs a slow sequence that spells out the decimal value of a 9-bit start address. Analog mode, preset mode, preset save, data error and mains failure each have their own glyph. Each symbol is mapped to an active-low segment pattern. The pattern is sent only when the chosen symbol differs from the last one sent, so the link stays quiet while the display is steady.

The long hold interval is counted in pulses on `hold_tick_i`, one per mains half-cycle. With the default of 250 ticks this gives about 2.5 s at 100 Hz. A sequential double-dabble converter runs all the time. It splits the address into hundreds, tens and ones long before the first digit is due.

Top module: `seg_status_seq`

## Requirements
- R1: A transfer sends 8 bits, least significant first. `seg_dat_o` changes only while `seg_clk_o` is low, and each bit is taken on a rising edge of `seg_clk_o`. Both outputs are low in reset, and `seg_clk_o` is low between transfers.
- R2: A transfer starts only when the selected symbol differs from the symbol last sent. After reset the last-sent symbol is blank (pattern 255), so a symbol that repeats produces no transfer.
- R3: The address is shown as decimal hundreds, tens and ones, using the digit patterns 0=129, 1=243, 3=97, 4=51, 5=37, 6=7 and 7=241. The digits follow any address that has been stable for 2*(ADDR_W+1) cycles.
- R4: When `data_valid_i` rises, the display shows d (67) and the hold counter restarts. Each expiry of the hold counter (HOLD_TICKS ticks) advances the display from d to hundreds, then tens, then ones, then back to d, where it stays.
- R5: `seg_clk_o` stays high for exactly HALF_DIV cycles and low for at least HALF_DIV cycles during a transfer, where HALF_DIV is at least 2.
- R6: While `data_valid_i` and `data_err_i` are both high, the display shows E (13) and the sequence does not advance. When the error clears, the current sequence symbol returns.
- R7: When no other mode is active, the display shows A (17).
- R8: `mains_fail_i` overrides every other mode and shows symbol 15, whose pattern is 23.
- R9: When preset mode starts without data mode, the display shows P (25) and the hold counter restarts. After one hold interval it shows `preset_num_i`, or blank (255) if that value is above 9.
- R10: In preset mode without data mode, `preset_save_i` shows c (79) and takes priority over P and the preset number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Start address shown in decimal |
| hold_tick_i | input | 1 | One-cycle pulse per mains half-cycle |
| data_valid_i | input | 1 | Data-receive mode active |
| data_err_i | input | 1 | Receive error in data mode |
| preset_mode_i | input | 1 | Preset mode selected |
| preset_save_i | input | 1 | Preset save in progress |
| mains_fail_i | input | 1 | Mains failure present |
| preset_num_i | input | 4 | Current preset number |
| seg_clk_o | output | 1 | Shift clock to display register |
| seg_dat_o | output | 1 | Serial segment data |

## Verification
The assertions check on every cycle that data moves only while the clock is low, that clock high and low phases meet the minimum width, that exactly eight rising edges occur per transfer, that a transfer starts only on a symbol change, and that mains failure always selects its glyph. Only the bench scenarios can show the actual patterns, the digit order for particular addresses, and the timing of sequence steps against hold ticks. The same holds for the suppression of a repeated digit (tens equal to ones), the preset intro and its blank for numbers above 9, and the return to the sequence after an error clears.

// File: rtl/seg_status_pkg.sv
package seg_status_pkg;

  typedef logic [4:0] sym_t;

  localparam sym_t SYM_D     = 5'd10;
  localparam sym_t SYM_A     = 5'd11;
  localparam sym_t SYM_P     = 5'd12;
  localparam sym_t SYM_E     = 5'd13;
  localparam sym_t SYM_C     = 5'd14;
  localparam sym_t SYM_H     = 5'd15;
  localparam sym_t SYM_BLANK = 5'd16;

  typedef enum logic [1:0] {SQ_OFF, SQ_D, SQ_DIG, SQ_HOLD} seq_t;

  // active-low segment patterns, bit 0 shifted first
  function automatic logic [7:0] sym_pattern(sym_t s);
    case (s)
      5'd0:    return 8'd129;
      5'd1:    return 8'd243;
      5'd2:    return 8'd73;
      5'd3:    return 8'd97;
      5'd4:    return 8'd51;
      5'd5:    return 8'd37;
      5'd6:    return 8'd7;
      5'd7:    return 8'd241;
      5'd8:    return 8'd1;
      5'd9:    return 8'd49;
      5'd10:   return 8'd67;
      5'd11:   return 8'd17;
      5'd12:   return 8'd25;
      5'd13:   return 8'd13;
      5'd14:   return 8'd79;
      5'd15:   return 8'd23;
      default: return 8'd255;
    endcase
  endfunction

endpackage

// File: rtl/seg_bcd_conv.sv
module seg_bcd_conv #(
  parameter int ADDR_W = 9,
  parameter int DIG_N  = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [4*DIG_N-1:0]   digits_o
);

  localparam int CW = $clog2(ADDR_W + 1);
  localparam int BW = 4 * DIG_N;

  logic [ADDR_W-1:0] sh;
  logic [BW-1:0]     bcd, bcd_adj;
  logic [CW-1:0]     cnt;

  for (genvar g = 0; g < DIG_N; g++) begin : g_adj
    assign bcd_adj[4*g +: 4] = (bcd[4*g +: 4] >= 4'd5) ? bcd[4*g +: 4] + 4'd3
                                                       : bcd[4*g +: 4];
  end

  // free-running double dabble; one pass per ADDR_W+1 cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh       <= '0;
      bcd      <= '0;
      cnt      <= CW'(ADDR_W);
      digits_o <= '0;
    end else if (cnt == CW'(ADDR_W)) begin
      digits_o <= bcd;
      bcd      <= '0;
      sh       <= addr_i;
      cnt      <= '0;
    end else begin
      {bcd, sh} <= {bcd_adj[BW-2:0], sh, 1'b0};
      cnt       <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/seg_sym_select.sv
module seg_sym_select
  import seg_status_pkg::*;
#(
  parameter int HOLD_TICKS = 250,
  parameter int DIG_N      = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hold_tick_i,
  input  logic               data_valid_i,
  input  logic               data_err_i,
  input  logic               preset_mode_i,
  input  logic               preset_save_i,
  input  logic               mains_fail_i,
  input  logic [3:0]         preset_num_i,
  input  logic [4*DIG_N-1:0] digits_i,
  output sym_t               sym_o
);

  localparam int HCW = $clog2(HOLD_TICKS + 1);
  localparam int ICW = $clog2(DIG_N + 1);

  logic [HCW-1:0] hold_cnt;
  logic [ICW-1:0] dig_idx;
  seq_t           seq;
  logic           data_q, pre_q, pre_done;
  logic           pre_act, expire;
  logic [3:0]     cur_dig;

  assign pre_act = preset_mode_i && !data_valid_i;
  assign expire  = hold_tick_i && (hold_cnt == HCW'(HOLD_TICKS - 1));
  assign cur_dig = digits_i[4*dig_idx +: 4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_cnt <= '0;
      dig_idx  <= '0;
      seq      <= SQ_OFF;
      data_q   <= 1'b0;
      pre_q    <= 1'b0;
      pre_done <= 1'b0;
    end else begin
      data_q <= data_valid_i;
      pre_q  <= pre_act;
      if (data_valid_i && !data_q) begin
        seq      <= SQ_D;
        hold_cnt <= '0;
      end else if (pre_act && !pre_q) begin
        pre_done <= 1'b0;
        hold_cnt <= '0;
      end else if (hold_tick_i) begin
        hold_cnt <= expire ? '0 : hold_cnt + 1'b1;
        if (expire && data_valid_i && !data_err_i) begin
          unique case (seq)
            SQ_D: begin
              seq     <= SQ_DIG;
              dig_idx <= ICW'(DIG_N - 1);
            end
            SQ_DIG: begin
              if (dig_idx == '0) seq <= SQ_HOLD;
              else               dig_idx <= dig_idx - 1'b1;
            end
            default: ;
          endcase
        end
        if (expire && pre_act) pre_done <= 1'b1;
      end
      if (!data_valid_i) seq <= SQ_OFF;
      if (!pre_act)      pre_done <= 1'b0;
    end
  end

  always_comb begin
    if (mains_fail_i) begin
      sym_o = SYM_H;
    end else if (data_valid_i) begin
      if (data_err_i)          sym_o = SYM_E;
      else if (seq == SQ_DIG)  sym_o = sym_t'({1'b0, cur_dig});
      else                     sym_o = SYM_D;
    end else if (preset_mode_i) begin
      if (preset_save_i)             sym_o = SYM_C;
      else if (!pre_done)            sym_o = SYM_P;
      else if (preset_num_i > 4'd9)  sym_o = SYM_BLANK;
      else                           sym_o = sym_t'({1'b0, preset_num_i});
    end else begin
      sym_o = SYM_A;
    end
  end

endmodule

// File: rtl/seg_shifter.sv
module seg_shifter
  import seg_status_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  sym_t req_sym_i,
  output sym_t last_sym_o,
  output logic busy_o,
  output logic sclk_o,
  output logic sdat_o
);

  localparam int DW = $clog2(HALF_DIV + 1);

  logic [DW-1:0] div_cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    pat, next_pat;

  assign next_pat = sym_pattern(req_sym_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      sclk_o     <= 1'b0;
      sdat_o     <= 1'b0;
      bit_idx    <= '0;
      div_cnt    <= '0;
      pat        <= '1;
      last_sym_o <= SYM_BLANK;
    end else if (!busy_o) begin
      div_cnt <= '0;
      if (req_sym_i != last_sym_o) begin
        busy_o     <= 1'b1;
        last_sym_o <= req_sym_i;
        pat        <= next_pat;
        sdat_o     <= next_pat[0];
        bit_idx    <= '0;
        sclk_o     <= 1'b0;
      end
    end else if (div_cnt != DW'(HALF_DIV - 1)) begin
      div_cnt <= div_cnt + 1'b1;
    end else begin
      div_cnt <= '0;
      if (!sclk_o) begin
        sclk_o <= 1'b1;
      end else begin
        sclk_o <= 1'b0;
        if (bit_idx == 3'd7) begin
          busy_o <= 1'b0;
        end else begin
          bit_idx <= bit_idx + 3'd1;
          sdat_o  <= pat[3'(bit_idx + 3'd1)];
        end
      end
    end
  end

endmodule

// File: rtl/seg_status_seq.sv
module seg_status_seq
  import seg_status_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int HOLD_TICKS = 250,
  parameter int HALF_DIV   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hold_tick_i,
  input  logic              data_valid_i,
  input  logic              data_err_i,
  input  logic              preset_mode_i,
  input  logic              preset_save_i,
  input  logic              mains_fail_i,
  input  logic [3:0]        preset_num_i,
  output logic              seg_clk_o,
  output logic              seg_dat_o
);

  localparam int DIG_N = (ADDR_W * 30103) / 100000 + 1;

  logic [4*DIG_N-1:0] digits;
  sym_t               req_sym, last_sym;
  logic               shift_busy;

  seg_bcd_conv #(.ADDR_W(ADDR_W), .DIG_N(DIG_N)) i_conv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .digits_o (digits)
  );

  seg_sym_select #(.HOLD_TICKS(HOLD_TICKS), .DIG_N(DIG_N)) i_sel (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hold_tick_i   (hold_tick_i),
    .data_valid_i  (data_valid_i),
    .data_err_i    (data_err_i),
    .preset_mode_i (preset_mode_i),
    .preset_save_i (preset_save_i),
    .mains_fail_i  (mains_fail_i),
    .preset_num_i  (preset_num_i),
    .digits_i      (digits),
    .sym_o         (req_sym)
  );

  seg_shifter #(.HALF_DIV(HALF_DIV)) i_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_sym_i  (req_sym),
    .last_sym_o (last_sym),
    .busy_o     (shift_busy),
    .sclk_o     (seg_clk_o),
    .sdat_o     (seg_dat_o)
  );

endmodule

// File: rtl/seg_status_seq_chk.sv
module seg_status_seq_chk
  import seg_status_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic mains_fail_i,
  input logic seg_clk_o,
  input logic seg_dat_o,
  input logic shift_busy,
  input sym_t req_sym,
  input sym_t last_sym
);

  logic       clk_q;
  logic [3:0] rise_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q    <= 1'b0;
      rise_cnt <= '0;
    end else begin
      clk_q <= seg_clk_o;
      if (!shift_busy)                rise_cnt <= '0;
      else if (seg_clk_o && !clk_q)   rise_cnt <= rise_cnt + 4'd1;
    end
  end

  a_r1_data_moves_clk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(seg_dat_o) |-> !seg_clk_o);

  a_r1_eight_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shift_busy) |-> rise_cnt == 4'd8);

  a_r1_clk_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seg_clk_o) |-> shift_busy);

  a_r2_start_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shift_busy) |-> $past(req_sym) != $past(last_sym));

  a_r5_high_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seg_clk_o) |=> seg_clk_o);

  a_r5_low_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(seg_clk_o) |=> !seg_clk_o);

  a_r8_mains_glyph: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mains_fail_i |-> req_sym == SYM_H);

endmodule

bind seg_status_seq seg_status_seq_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mains_fail_i (mains_fail_i),
  .seg_clk_o    (seg_clk_o),
  .seg_dat_o    (seg_dat_o),
  .shift_busy   (shift_busy),
  .req_sym      (req_sym),
  .last_sym     (last_sym)
);

// File: tb/test_seg_status_seq.sv
`timescale 1ns/1ps
module test_seg_status_seq;

  localparam int HOLD = 3;
  localparam int HDIV = 2;
  localparam int SETTLE = 50;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [8:0] addr_i = '0;
  logic       hold_tick_i = 1'b0;
  logic       data_valid_i = 1'b0;
  logic       data_err_i = 1'b0;
  logic       preset_mode_i = 1'b0;
  logic       preset_save_i = 1'b0;
  logic       mains_fail_i = 1'b0;
  logic [3:0] preset_num_i = '0;
  logic       seg_clk_o, seg_dat_o;

  int n_tests = 0;
  int n_fail  = 0;
  int frames  = 0;
  int nbits   = 0;
  logic [7:0] shreg = '0;
  logic [7:0] last_frame = '0;
  bit   done = 0;

  always #10 clk_i = ~clk_i;

  seg_status_seq #(.ADDR_W(9), .HOLD_TICKS(HOLD), .HALF_DIV(HDIV)) i_seg_status_seq (
    .clk_i, .rst_ni, .addr_i, .hold_tick_i, .data_valid_i, .data_err_i,
    .preset_mode_i, .preset_save_i, .mains_fail_i, .preset_num_i,
    .seg_clk_o, .seg_dat_o
  );

  // receiver model of the external shift register
  always @(posedge seg_clk_o) begin
    shreg = {seg_dat_o, shreg[7:1]};
    nbits = nbits + 1;
    if (nbits == 8) begin
      last_frame = shreg;
      frames = frames + 1;
      nbits = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) hold_tick_i = 1'b1;
      @(negedge clk_i) hold_tick_i = 1'b0;
      cyc(2);
    end
  endtask

  // expect exactly one new frame with the given pattern
  task automatic expect_frame(input int f0, input string req, input int pat);
    cyc(SETTLE);
    chk(frames == f0 + 1, {req, " frame count"}, frames - f0, 1);
    chk(last_frame == 8'(pat), {req, " pattern"}, last_frame, pat);
    chk(seg_clk_o == 1'b0, {req, " R1 idle clock low"}, seg_clk_o, 0);
  endtask

  task automatic expect_none(input int f0, input string req);
    cyc(SETTLE);
    chk(frames == f0, {req, " no transfer"}, frames - f0, 0);
  endtask

  task automatic t_reset();
    int n;
    addr_i = 9'd437;
    cyc(3);
    chk(seg_clk_o == 1'b0, "R1 reset clock", seg_clk_o, 0);
    chk(seg_dat_o == 1'b0, "R1 reset data", seg_dat_o, 0);
    rst_ni = 1'b1;
    // R5 high phase width
    @(posedge seg_clk_o);
    n = 0;
    @(negedge clk_i);
    while (seg_clk_o) begin
      n++;
      @(negedge clk_i);
    end
    chk(n == HDIV, "R5 clock high width", n, HDIV);
    cyc(SETTLE);
    chk(frames == 1, "R7 frame count", frames, 1);
    chk(last_frame == 8'd17, "R7 analog glyph A", last_frame, 17);
  endtask

  task automatic t_no_repeat();
    int f0 = frames;
    cyc(200);
    chk(frames == f0, "R2 steady symbol not resent", frames - f0, 0);
  endtask

  task automatic t_data_seq();
    int f0 = frames;
    @(negedge clk_i) data_valid_i = 1'b1;
    expect_frame(f0, "R4 entry d", 67);
    f0 = frames;
    ticks(HOLD - 1);
    expect_none(f0, "R4 before expiry");
    ticks(1);
    expect_frame(f0, "R3 hundreds of 437", 51);
    f0 = frames; ticks(HOLD);
    expect_frame(f0, "R3 tens of 437", 97);
    f0 = frames; ticks(HOLD);
    expect_frame(f0, "R3 ones of 437", 241);
    f0 = frames; ticks(HOLD);
    expect_frame(f0, "R4 back to d", 67);
    f0 = frames; ticks(2 * HOLD);
    expect_none(f0, "R4 d held");
  endtask

  task automatic t_repeat_digit();
    int f0 = frames;
    @(negedge clk_i) data_valid_i = 1'b0;
    addr_i = 9'd511;
    expect_frame(f0, "R7 analog after data", 17);
    f0 = frames;
    @(negedge clk_i) data_valid_i = 1'b1;
    expect_frame(f0, "R4 re-entry d", 67);
    f0 = frames; ticks(HOLD);
    expect_frame(f0, "R3 hundreds of 511", 37);
    f0 = frames; ticks(HOLD);
    expect_frame(f0, "R3 tens of 511", 243);
    f0 = frames; ticks(HOLD);
    expect_none(f0, "R2 ones equal tens");
    f0 = frames; ticks(HOLD);
    expect_frame(f0, "R4 d after 511", 67);
  endtask

  task automatic t_zero_digits();
    int f0 = frames;
    @(negedge clk_i) data_valid_i = 1'b0;
    addr_i = 9'd60;
    cyc(SETTLE);
    f0 = frames;
    @(negedge clk_i) data_valid_i = 1'b1;
    expect_frame(f0, "R4 entry for 60", 67);
    f0 = frames; ticks(HOLD);
    expect_frame(f0, "R3 hundreds of 60", 129);
    f0 = frames; ticks(HOLD);
    expect_frame(f0, "R3 tens of 60", 7);
    f0 = frames; ticks(HOLD);
    expect_frame(f0, "R3 ones of 60", 129);
  endtask

  task automatic t_error();
    int f0 = frames;
    @(negedge clk_i) data_err_i = 1'b1;
    expect_frame(f0, "R6 error glyph E", 13);
    f0 = frames; ticks(2 * HOLD);
    expect_none(f0, "R6 sequence paused");
    @(negedge clk_i) data_err_i = 1'b0;
    expect_frame(f0, "R6 resume ones digit", 129);
  endtask

  task automatic t_mains();
    int f0 = frames;
    @(negedge clk_i) begin mains_fail_i = 1'b1; data_err_i = 1'b1; end
    expect_frame(f0, "R8 mains over error", 23);
    f0 = frames;
    @(negedge clk_i) begin data_err_i = 1'b0; data_valid_i = 1'b0; preset_mode_i = 1'b1; end
    expect_none(f0, "R8 mains holds over preset");
    @(negedge clk_i) begin mains_fail_i = 1'b0; preset_mode_i = 1'b0; end
    expect_frame(f0, "R7 analog after mains", 17);
  endtask

  task automatic t_preset();
    int f0 = frames;
    preset_num_i = 4'd7;
    @(negedge clk_i) preset_mode_i = 1'b1;
    expect_frame(f0, "R9 preset intro P", 25);
    f0 = frames; ticks(HOLD - 1);
    expect_none(f0, "R9 intro held");
    ticks(1);
    expect_frame(f0, "R9 preset number 7", 241);
    f0 = frames;
    @(negedge clk_i) preset_save_i = 1'b1;
    expect_frame(f0, "R10 save glyph c", 79);
    f0 = frames;
    @(negedge clk_i) preset_save_i = 1'b0;
    expect_frame(f0, "R9 number after save", 241);
    f0 = frames;
    @(negedge clk_i) preset_num_i = 4'd12;
    expect_frame(f0, "R9 number above 9 blank", 255);
    f0 = frames;
    @(negedge clk_i) preset_mode_i = 1'b0;
    expect_frame(f0, "R7 analog after preset", 17);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_no_repeat();
    t_data_seq();
    t_repeat_digit();
    t_zero_digits();
    t_error();
    t_mains();
    t_preset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule